// File: doc/BRIEF.md
# Single-Wire Bus Command Sequencer

This block sends one function command over a single-wire bus with an open-drain line. One start strobe makes it run a complete bus transaction without further help. It first drives a bus reset pulse. It then sends a ROM-level addressing byte. When one device is addressed, the eight bytes of that device's identifier follow. The function command byte comes last. Every byte goes out least significant bit first. Each bit becomes one timed slot, produced by an internal slot timer. When the last slot's recovery interval has passed, the block pulses `done`. Any data phase that follows the command belongs to other logic.

The caller can ask for a strong pull-up after the command. In that case only the final (eighth) slot of the command byte raises `strong_pullup`, starting at the moment that slot releases the line. The output stays high after `done` until the next accepted start. Parasite-powered devices therefore get power with no gap.

The controller has six named states:
- `SQ_IDLE` goes to `SQ_RST_GO` when start is seen.
- `SQ_RST_GO` goes to `SQ_RST_WAIT`, which launches the reset pulse.
- `SQ_RST_WAIT` goes to `SQ_BIT_GO` when the timer finishes.
- `SQ_BIT_GO` goes to `SQ_BIT_WAIT`, which launches one slot.
- `SQ_BIT_WAIT` goes back to `SQ_BIT_GO` after a slot that is not the last one. After the final command slot it goes to `SQ_DONE`.
- `SQ_DONE` goes to `SQ_IDLE`.

A byte-phase register tracks where the sequence is: addressing byte, identifier bytes, or command byte.

Top module: `ow_cmd_seq`

## Requirements
- R1: The cycle after a start is accepted, the line is released. The line is then driven low for T_RST_LOW cycles, and released for T_RST_HIGH cycles. No presence result is used; the sequence always continues.
- R2: With `single_dev`=1, the first byte sent is 0x55. It is followed by the identifier bytes in order, byte k being `dev_id[8k+7:8k]`, starting at k=0.
- R3: With `single_dev`=0, the first byte sent is 0xCC and no identifier byte is sent. The command byte follows directly.
- R4: Each byte goes out bit 0 first. Each bit takes one released gap cycle, then a slot of T_SLOT cycles, then T_REC released cycles. In a 1-slot the line is low only for the first T_INIT slot cycles. In a 0-slot the line is low for all T_SLOT cycles. The command byte is sent last.
- R5: `done` is high for exactly one cycle: the cycle after the last recovery cycle of the command's eighth slot. `busy` is high from the cycle after acceptance through that `done` cycle.
- R6: With `pullup_after`=1, `strong_pullup` rises in the first recovery cycle of the command's eighth slot. It stays high until the next start is accepted. It is never high during earlier slots.
- R7: With `pullup_after`=0, `strong_pullup` stays low for the whole sequence and afterwards.
- R8: A start strobe while `busy` is ignored. Inputs are captured at acceptance, so changes to them during the sequence have no effect on the line.
- R9: After reset, and whenever idle, the line is released and `busy` and `done` are low.
- R10: The line is never driven low while `strong_pullup` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| cmd_byte | input | 8 | Function command byte |
| dev_id | input | 8*ID_BYTES | Device identifier, byte 0 in bits 7:0 |
| single_dev | input | 1 | 1: address one device, 0: address all |
| pullup_after | input | 1 | Request strong pull-up after the command |
| bus_drive_low | output | 1 | 1: pull the bus line low |
| strong_pullup | output | 1 | Strong pull-up request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result has a cycle position fixed relative to the edge that accepts start.
- The first released cycle is due one cycle after acceptance.
- The reset low starts one cycle after that.
- Each slot comes after one gap cycle.
- The strong pull-up comes in the first recovery cycle of the final slot.
- `done` comes one cycle after the final recovery.

The bench builds a per-cycle queue of the expected line, pull-up, busy and done levels from these rules. It compares one entry on each falling edge. Outputs are therefore sampled half a cycle after the register that drives them has settled. A stray start and changed inputs are injected in some runs without touching the expected queue.

// File: rtl/ow_cmd_seq_pkg.sv
package ow_cmd_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RST_GO,
        SQ_RST_WAIT,
        SQ_BIT_GO,
        SQ_BIT_WAIT,
        SQ_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_ID,
        PH_CMD
    } seq_phase_t;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_RST_LO,
        EN_RST_HI,
        EN_SLOT,
        EN_REC
    } eng_state_t;

    localparam logic [7:0] ROM_ONE_DEV  = 8'h55;
    localparam logic [7:0] ROM_ALL_DEV  = 8'hCC;

endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
    import ow_cmd_seq_pkg::*;
#(
    parameter int T_RST_LOW  = 40,
    parameter int T_RST_HIGH = 40,
    parameter int T_INIT     = 2,
    parameter int T_SLOT     = 12,
    parameter int T_REC      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_reset,
    input  logic go_slot,
    input  logic slot_bit,
    output logic line_low,
    output logic slot_end,
    output logic op_done
);

    localparam int MAX_A = (T_RST_LOW > T_RST_HIGH) ? T_RST_LOW : T_RST_HIGH;
    localparam int MAX_B = (T_SLOT > T_REC) ? T_SLOT : T_REC;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXT + 1);

    localparam logic [CW-1:0] LAST_RLO  = CW'(T_RST_LOW - 1);
    localparam logic [CW-1:0] LAST_RHI  = CW'(T_RST_HIGH - 1);
    localparam logic [CW-1:0] LAST_SLOT = CW'(T_SLOT - 1);
    localparam logic [CW-1:0] LAST_REC  = CW'(T_REC - 1);
    localparam logic [CW-1:0] INIT_C    = CW'(T_INIT);

    eng_state_t    st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          bit_q;
    logic          at_last;

    always_comb begin
        unique case (st)
            EN_RST_LO: limit = LAST_RLO;
            EN_RST_HI: limit = LAST_RHI;
            EN_SLOT:   limit = LAST_SLOT;
            EN_REC:    limit = LAST_REC;
            default:   limit = '0;
        endcase
        at_last = (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= EN_IDLE;
            cnt   <= '0;
            bit_q <= 1'b0;
        end else begin
            unique case (st)
                EN_IDLE: begin
                    cnt <= '0;
                    if (go_reset) begin
                        st <= EN_RST_LO;
                    end else if (go_slot) begin
                        st    <= EN_SLOT;
                        bit_q <= slot_bit;
                    end
                end
                EN_RST_LO: begin
                    cnt <= at_last ? '0 : cnt + CW'(1);
                    if (at_last) st <= EN_RST_HI;
                end
                EN_RST_HI: begin
                    cnt <= at_last ? '0 : cnt + CW'(1);
                    if (at_last) st <= EN_IDLE;
                end
                EN_SLOT: begin
                    cnt <= at_last ? '0 : cnt + CW'(1);
                    if (at_last) st <= EN_REC;
                end
                EN_REC: begin
                    cnt <= at_last ? '0 : cnt + CW'(1);
                    if (at_last) st <= EN_IDLE;
                end
                default: begin
                    st  <= EN_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        line_low = (st == EN_RST_LO) ||
                   ((st == EN_SLOT) && (!bit_q || (cnt < INIT_C)));
        slot_end = (st == EN_SLOT) && at_last;
        op_done  = ((st == EN_RST_HI) || (st == EN_REC)) && at_last;
    end

endmodule

// File: rtl/ow_byte_pick.sv
module ow_byte_pick
    import ow_cmd_seq_pkg::*;
#(
    parameter int ID_BYTES = 8,
    localparam int IDX_W   = $clog2(ID_BYTES)
) (
    input  seq_phase_t         phase,
    input  logic [IDX_W-1:0]   id_idx,
    input  logic               single_dev,
    input  logic [ID_BYTES*8-1:0] dev_id,
    input  logic [7:0]         cmd_byte,
    output logic [7:0]         cur_byte
);

    logic [7:0] id_bytes [ID_BYTES];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_split
        assign id_bytes[g] = dev_id[g*8 +: 8];
    end

    always_comb begin
        unique case (phase)
            PH_ADDR: cur_byte = single_dev ? ROM_ONE_DEV : ROM_ALL_DEV;
            PH_ID:   cur_byte = id_bytes[id_idx];
            PH_CMD:  cur_byte = cmd_byte;
            default: cur_byte = cmd_byte;
        endcase
    end

endmodule

// File: rtl/ow_cmd_seq.sv
module ow_cmd_seq
    import ow_cmd_seq_pkg::*;
#(
    parameter int T_RST_LOW  = 40,
    parameter int T_RST_HIGH = 40,
    parameter int T_INIT     = 2,
    parameter int T_SLOT     = 12,
    parameter int T_REC      = 2,
    parameter int ID_BYTES   = 8,
    localparam int ID_W      = ID_BYTES * 8,
    localparam int IDX_W     = $clog2(ID_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      cmd_byte,
    input  logic [ID_W-1:0] dev_id,
    input  logic            single_dev,
    input  logic            pullup_after,
    output logic            bus_drive_low,
    output logic            strong_pullup,
    output logic            busy,
    output logic            done
);

    localparam logic [IDX_W-1:0] LAST_ID = IDX_W'(ID_BYTES - 1);

    seq_state_t       st, st_nx;
    seq_phase_t       phase;
    logic [IDX_W-1:0] id_idx;
    logic [2:0]       bit_idx;
    logic [7:0]       cmd_q;
    logic [ID_W-1:0]  id_q;
    logic             single_q;
    logic             pu_q;
    logic             spu_q;

    logic             go_reset, go_slot, slot_bit;
    logic             line_low, slot_end, op_done;
    logic [7:0]       cur_byte;
    logic             final_bit;

    ow_slot_timer #(
        .T_RST_LOW (T_RST_LOW),
        .T_RST_HIGH(T_RST_HIGH),
        .T_INIT    (T_INIT),
        .T_SLOT    (T_SLOT),
        .T_REC     (T_REC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_reset(go_reset),
        .go_slot (go_slot),
        .slot_bit(slot_bit),
        .line_low(line_low),
        .slot_end(slot_end),
        .op_done (op_done)
    );

    ow_byte_pick #(
        .ID_BYTES(ID_BYTES)
    ) u_pick (
        .phase     (phase),
        .id_idx    (id_idx),
        .single_dev(single_q),
        .dev_id    (id_q),
        .cmd_byte  (cmd_q),
        .cur_byte  (cur_byte)
    );

    assign final_bit = (phase == PH_CMD) && (bit_idx == 3'd7);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:     if (start) st_nx = SQ_RST_GO;
            SQ_RST_GO:   st_nx = SQ_RST_WAIT;
            SQ_RST_WAIT: if (op_done) st_nx = SQ_BIT_GO;
            SQ_BIT_GO:   st_nx = SQ_BIT_WAIT;
            SQ_BIT_WAIT: if (op_done) st_nx = final_bit ? SQ_DONE : SQ_BIT_GO;
            SQ_DONE:     st_nx = SQ_IDLE;
            default:     st_nx = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    // captured inputs, byte position and pull-up request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_ADDR;
            id_idx   <= '0;
            bit_idx  <= '0;
            cmd_q    <= '0;
            id_q     <= '0;
            single_q <= 1'b0;
            pu_q     <= 1'b0;
            spu_q    <= 1'b0;
        end else begin
            if ((st == SQ_IDLE) && start) begin
                cmd_q    <= cmd_byte;
                id_q     <= dev_id;
                single_q <= single_dev;
                pu_q     <= pullup_after;
                spu_q    <= 1'b0;
            end
            if ((st == SQ_RST_WAIT) && op_done) begin
                phase   <= PH_ADDR;
                id_idx  <= '0;
                bit_idx <= '0;
            end
            if ((st == SQ_BIT_WAIT) && op_done) begin
                if (bit_idx != 3'd7) begin
                    bit_idx <= bit_idx + 3'd1;
                end else begin
                    bit_idx <= '0;
                    unique case (phase)
                        PH_ADDR: phase <= single_q ? PH_ID : PH_CMD;
                        PH_ID: begin
                            if (id_idx == LAST_ID) phase <= PH_CMD;
                            else                   id_idx <= id_idx + IDX_W'(1);
                        end
                        default: phase <= PH_CMD;
                    endcase
                end
            end
            if (slot_end && final_bit && pu_q) spu_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        go_reset      = (st == SQ_RST_GO);
        go_slot       = (st == SQ_BIT_GO);
        slot_bit      = cur_byte[bit_idx];
        busy          = (st != SQ_IDLE);
        done          = (st == SQ_DONE);
        strong_pullup = spu_q;
        bus_drive_low = line_low;
    end

endmodule

// File: rtl/ow_cmd_seq_chk.sv
module ow_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic bus_drive_low,
    input logic strong_pullup
);

    // R10
    pullup_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strong_pullup |-> !bus_drive_low);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6
    accept_clears_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !strong_pullup && !bus_drive_low));

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_drive_low && !done));

    // R6
    pu_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strong_pullup) |-> (busy && !done));

endmodule

bind ow_cmd_seq ow_cmd_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .bus_drive_low(bus_drive_low),
    .strong_pullup(strong_pullup)
);

// File: tb/ow_cmd_seq_test.sv
module ow_cmd_seq_test;

    localparam int RLO = 40, RHI = 40, INI = 2, SLT = 12, REC = 2, NB = 8;

    typedef struct {
        bit    drv;
        bit    spu;
        bit    bsy;
        bit    dn;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      cmd_byte = '0;
    logic [NB*8-1:0] dev_id = '0;
    logic            single_dev = 1'b0;
    logic            pullup_after = 1'b0;
    logic            bus_drive_low, strong_pullup, busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ow_cmd_seq #(
        .T_RST_LOW(RLO), .T_RST_HIGH(RHI), .T_INIT(INI),
        .T_SLOT(SLT), .T_REC(REC), .ID_BYTES(NB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_byte(cmd_byte),
        .dev_id(dev_id), .single_dev(single_dev), .pullup_after(pullup_after),
        .bus_drive_low(bus_drive_low), .strong_pullup(strong_pullup),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R5: busy=%b expected 0", busy);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    exp_t q[$];

    function automatic void push(bit d, bit s, bit b, bit n, string t);
        exp_t e;
        e.drv = d; e.spu = s; e.bsy = b; e.dn = n; e.tag = t;
        q.push_back(e);
    endfunction

    task automatic cmp(exp_t e, int i);
        checks++;
        if (bus_drive_low !== e.drv || strong_pullup !== e.spu ||
            busy !== e.bsy || done !== e.dn) begin
            errors++;
            $display("FAIL %s cycle %0d: drv/spu/busy/done=%b%b%b%b expected %b%b%b%b",
                     e.tag, i, bus_drive_low, strong_pullup, busy, done,
                     e.drv, e.spu, e.bsy, e.dn);
        end
        // R10: never pull low under strong pull-up
        checks++;
        if (strong_pullup && bus_drive_low) begin
            errors++;
            $display("FAIL R10 cycle %0d: drv=%b expected 0", i, bus_drive_low);
        end
    endtask

    task automatic run_seq(input logic [7:0] c, input logic [NB*8-1:0] id,
                           input bit sg, input bit pu, input int inj);
        logic [7:0] bytes[$];
        bit sp = 1'b0;
        string sfx;
        sfx = (inj >= 0) ? " R8" : "";
        q.delete();
        // R1: released gap, reset low, reset high
        push(0, 0, 1, 0, {"R1", sfx});
        for (int k = 0; k < RLO; k++) push(1, 0, 1, 0, {"R1", sfx});
        for (int k = 0; k < RHI; k++) push(0, 0, 1, 0, {"R1", sfx});
        bytes.push_back(sg ? 8'h55 : 8'hCC);
        if (sg) for (int k = 0; k < NB; k++) bytes.push_back(id[k*8 +: 8]);
        bytes.push_back(c);
        for (int b = 0; b < bytes.size(); b++) begin
            string t;
            bit is_cmd = (b == bytes.size() - 1);
            t = is_cmd ? "R4" : (sg ? "R2" : "R3");
            for (int j = 0; j < 8; j++) begin
                bit v = bytes[b][j];
                push(0, sp, 1, 0, {t, sfx});
                for (int k = 0; k < SLT; k++) push((k < INI) || !v, sp, 1, 0, {t, sfx});
                if (is_cmd && j == 7 && pu) sp = 1'b1;
                for (int k = 0; k < REC; k++)
                    push(0, sp, 1, 0, {(is_cmd && j == 7) ? (pu ? "R6" : "R7") : t, sfx});
            end
        end
        push(0, sp, 1, 1, {"R5", sfx});
        for (int k = 0; k < 3; k++) push(0, sp, 0, 0, {pu ? "R6 R9" : "R7 R9", sfx});

        @(negedge clk);
        start = 1'b1; cmd_byte = c; dev_id = id; single_dev = sg; pullup_after = pu;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            cmp(q[i], i);
            if (i == inj) begin
                start = 1'b1; cmd_byte = ~c; dev_id = ~id;
                single_dev = ~sg; pullup_after = ~pu;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (bus_drive_low !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || strong_pullup !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: drv/busy/done/spu=%b%b%b%b expected 0000",
                     bus_drive_low, busy, done, strong_pullup);
        end
        // R3 R7: broadcast, no pull-up
        run_seq(8'h44, 64'h0, 1'b0, 1'b0, -1);
        // R2 R6: one device, pull-up after command
        run_seq(8'hBE, 64'h28FF_1234_5678_9A3C, 1'b1, 1'b1, -1);
        // R8 R6: broadcast with stray start mid-reset
        run_seq(8'h80, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b1, 30);
        // R8 R7: one device with stray start during id bytes
        run_seq(8'h01, 64'hA5C3_0F1E_7788_9911, 1'b1, 1'b0, 400);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule